// File: doc/BRIEF.md
# Dual-Bank ECC Error Reporter

This block sits behind a memory built from two 32-bit banks, an even bank and an odd bank. Each bank has its own ECC checker. For every access, each bank hands over a valid flag, a two-bit ECC result and its read data. The block folds the two results into a single reported error class and drives the bus response: OKAY, or ERROR for an uncorrectable error. It also passes each bank's data through, with one flag for a corrected lane and one for an uncorrectable lane.

An 8-bit configuration register chooses which error types are reported. When a reported error arrives and no earlier report is pending, the block latches the address, the access attributes, the master number, the data of the reported bank and the class. It then raises an interrupt. Software clears the interrupt and the captured details with a one-cycle clear pulse.

The bus response, the merged class and the data lanes are registered. They appear one clock cycle after the bank results are sampled.

Top module: `bank_ecc_reporter`

## Requirements
- R1: After an active-low reset, every output is zero: response, class, data lanes, flags, interrupt, captured fields and configuration readback.
- R2: When neither bank is valid, the next cycle shows rsp_valid=0, rsp_err=0 and class 0 (none). A bank whose valid flag is low has no effect, whatever its ECC code.
- R3: ECC codes are 00 none, 01 single-bit corrected, 10 multi-bit and 11 also multi-bit. Class codes are 0 none, 1 even single, 2 even multi, 3 odd single, 4 odd multi. When only one bank is valid, the class comes straight from that bank.
- R4: When both banks are valid, the class is that of the more severe bank (multi above single, single above none). On equal severity the even bank is reported.
- R5: rsp_err is 1 when a valid bank reports multi-bit, and 0 otherwise, including for single-bit errors. rsp_valid is the OR of the two valid flags.
- R6: rd_data holds the even bank data in bits 31:0 and the odd bank data in bits 63:32. A lane whose bank is not valid is zero. rd_fix[b] marks a single-bit result and rd_bad[b] a multi-bit result, with bit 0 for the even bank and bit 1 for the odd bank.
- R7: A cfg_we pulse loads cfg_wdata into the configuration register. Bit 0 enables reporting of multi-bit errors, bit 1 enables reporting of single-bit errors, and bits 7:2 read as zero on cfg_rdata.
- R8: When a reported error arrives and no interrupt is pending, the next cycle shows irq=1 and the capture fields: acc_addr, acc_attr, acc_mstr, the data of the reported bank, and the class.
- R9: An error whose type is disabled in the configuration captures nothing and raises no interrupt. Its bus response is still driven.
- R10: While irq is pending and no clear arrives, later errors leave irq and every captured field unchanged.
- R11: An irq_clr pulse drops irq and zeroes the captured fields in the next cycle. If a reported error arrives in the same cycle as the clear, that error is captured instead.
- R12: All results are registered. The values sampled at one rising edge appear on the outputs right after that edge and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_vld | input | 1 | Even bank takes part in the access |
| ev_ecc | input | 2 | Even bank ECC result |
| ev_data | input | 32 | Even bank read data |
| od_vld | input | 1 | Odd bank takes part in the access |
| od_ecc | input | 2 | Odd bank ECC result |
| od_data | input | 32 | Odd bank read data |
| acc_addr | input | 32 | Access address |
| acc_attr | input | 4 | Access attributes |
| acc_mstr | input | 4 | Number of the requesting master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration readback |
| irq_clr | input | 1 | Write-1 clear of the interrupt and capture |
| rsp_valid | output | 1 | A response is presented |
| rsp_err | output | 1 | Bus response is ERROR |
| rpt_class | output | 3 | Merged error class |
| rd_data | output | 64 | Passed-through bank data, odd bank in the upper half |
| rd_fix | output | 2 | Per-bank corrected flag |
| rd_bad | output | 2 | Per-bank uncorrectable flag |
| irq | output | 1 | Error interrupt |
| cap_class | output | 3 | Captured class |
| cap_addr | output | 32 | Captured address |
| cap_attr | output | 4 | Captured attributes |
| cap_mstr | output | 4 | Captured master number |
| cap_data | output | 32 | Captured data of the reported bank |

## Verification
Response, class, data lanes, capture fields and interrupt are each due exactly one rising edge after the bank results are presented. A configuration write takes effect for accesses sampled from the following edge on. The bench drives every stimulus just after a falling edge and checks at the next falling edge, where the edge between has just updated the registers. It returns the inputs to idle before the next rising edge, so each check sees one stimulus only. Hold and clear behaviour is checked in the cycle after the later error or the clear pulse, so a wrongly taken capture shows up at once.

// File: rtl/bank_ecc_pkg.sv
// Shared types and helpers for the dual-bank ECC reporter.
// Assumes a two-bit ECC code per bank in which 11 is treated as multi-bit.
package bank_ecc_pkg;

    localparam int CFG_W       = 8;
    localparam int CFG_MUL_BIT = 0;
    localparam int CFG_SGL_BIT = 1;
    localparam int NUM_BANKS   = 2;

    typedef enum logic [1:0] {
        SEV_NONE = 2'd0,
        SEV_SGL  = 2'd1,
        SEV_MUL  = 2'd2
    } sev_e;

    typedef enum logic [2:0] {
        RPT_NONE   = 3'd0,
        RPT_EV_SGL = 3'd1,
        RPT_EV_MUL = 3'd2,
        RPT_OD_SGL = 3'd3,
        RPT_OD_MUL = 3'd4
    } rpt_class_e;

    // Map a bank's valid flag and ECC code onto a severity rank.
    function automatic sev_e ecc_severity(input logic vld, input logic [1:0] code);
        if (!vld)            return SEV_NONE;
        else if (code == 2'b00) return SEV_NONE;
        else if (code == 2'b01) return SEV_SGL;
        else                 return SEV_MUL;
    endfunction

endpackage

// File: rtl/ecc_sev_merge.sv
// Folds the two bank results into one reported class.
// The more severe bank wins; on equal severity the even bank is reported.
// Purely combinational; the top registers its outputs.
module ecc_sev_merge
    import bank_ecc_pkg::*;
(
    input  logic       ev_vld,
    input  logic [1:0] ev_ecc,
    input  logic       od_vld,
    input  logic [1:0] od_ecc,
    output rpt_class_e cls,
    output logic       pick_odd,
    output logic       is_mul,
    output logic       is_sgl
);

    sev_e ev_sev;
    sev_e od_sev;
    sev_e top_sev;

    // Rank both banks and choose the winner, even bank on ties.
    always_comb begin
        ev_sev   = ecc_severity(ev_vld, ev_ecc);
        od_sev   = ecc_severity(od_vld, od_ecc);
        pick_odd = (od_sev > ev_sev);
        top_sev  = pick_odd ? od_sev : ev_sev;
    end

    // Turn the winning bank and its severity into a class code.
    always_comb begin
        is_mul = (top_sev == SEV_MUL);
        is_sgl = (top_sev == SEV_SGL);
        unique case (top_sev)
            SEV_SGL: cls = pick_odd ? RPT_OD_SGL : RPT_EV_SGL;
            SEV_MUL: cls = pick_odd ? RPT_OD_MUL : RPT_EV_MUL;
            default: cls = RPT_NONE;
        endcase
    end

endmodule

// File: rtl/ecc_lane_mark.sv
// One data lane: registers a bank's read data together with its
// corrected and uncorrectable marks. A lane that is not valid reads zero.
// Assumes the bank's own checker has already corrected single-bit data.
module ecc_lane_mark
    import bank_ecc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [1:0]        code,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] q_data,
    output logic              q_fix,
    output logic              q_bad
);

    sev_e sev;

    // Rank this lane's result.
    always_comb sev = ecc_severity(vld, code);

    // Register the lane data and its marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
            q_fix  <= 1'b0;
            q_bad  <= 1'b0;
        end else begin
            q_data <= vld ? data : '0;
            q_fix  <= (sev == SEV_SGL);
            q_bad  <= (sev == SEV_MUL);
        end
    end

endmodule

// File: rtl/ecc_cfg_reg.sv
// Configuration register selecting which error types are reported.
// Only the implemented enable bits are stored; the rest read as zero.
module ecc_cfg_reg
    import bank_ecc_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] IMPL_MASK = W'((1 << CFG_MUL_BIT) | (1 << CFG_SGL_BIT));

    // Load masked write data on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata & IMPL_MASK;
    end

endmodule

// File: rtl/ecc_fault_capture.sv
// Latches failure details and raises the interrupt on a reported error.
// While the interrupt is pending the details are frozen; a clear pulse
// releases them, and an error arriving with the clear is taken at once.
module ecc_fault_capture
    import bank_ecc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 4,
    parameter int MSTR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              report,
    input  logic              clr,
    input  rpt_class_e        cls,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ATTR_W-1:0] attr,
    input  logic [MSTR_W-1:0] mstr,
    input  logic [DATA_W-1:0] data,
    output logic              irq,
    output rpt_class_e        cap_class,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [ATTR_W-1:0] cap_attr,
    output logic [MSTR_W-1:0] cap_mstr,
    output logic [DATA_W-1:0] cap_data
);

    logic take;

    // A capture is allowed when nothing is pending or the pending one is cleared now.
    always_comb take = report && (!irq || clr);

    // Clear first, then capture, so a coincident error is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            cap_class <= RPT_NONE;
            cap_addr  <= '0;
            cap_attr  <= '0;
            cap_mstr  <= '0;
            cap_data  <= '0;
        end else begin
            if (clr) begin
                irq       <= 1'b0;
                cap_class <= RPT_NONE;
                cap_addr  <= '0;
                cap_attr  <= '0;
                cap_mstr  <= '0;
                cap_data  <= '0;
            end
            if (take) begin
                irq       <= 1'b1;
                cap_class <= cls;
                cap_addr  <= addr;
                cap_attr  <= attr;
                cap_mstr  <= mstr;
                cap_data  <= data;
            end
        end
    end

endmodule

// File: rtl/bank_ecc_reporter.sv
// Top of the dual-bank ECC reporter. Merges the per-bank ECC results,
// drives the registered bus response and data lanes, gates reporting by
// the configuration register and feeds the capture and interrupt logic.
// Assumes the bank results, data and access details are valid together
// in the cycle they are sampled.
module bank_ecc_reporter
    import bank_ecc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 4,
    parameter int MSTR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ev_vld,
    input  logic [1:0]                    ev_ecc,
    input  logic [DATA_W-1:0]             ev_data,
    input  logic                          od_vld,
    input  logic [1:0]                    od_ecc,
    input  logic [DATA_W-1:0]             od_data,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [ATTR_W-1:0]             acc_attr,
    input  logic [MSTR_W-1:0]             acc_mstr,
    input  logic                          cfg_we,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output logic [CFG_W-1:0]              cfg_rdata,
    input  logic                          irq_clr,
    output logic                          rsp_valid,
    output logic                          rsp_err,
    output logic [2:0]                    rpt_class,
    output logic [NUM_BANKS*DATA_W-1:0]   rd_data,
    output logic [NUM_BANKS-1:0]          rd_fix,
    output logic [NUM_BANKS-1:0]          rd_bad,
    output logic                          irq,
    output logic [2:0]                    cap_class,
    output logic [ADDR_W-1:0]             cap_addr,
    output logic [ATTR_W-1:0]             cap_attr,
    output logic [MSTR_W-1:0]             cap_mstr,
    output logic [DATA_W-1:0]             cap_data
);

    rpt_class_e             m_cls;
    logic                   m_pick_odd;
    logic                   m_mul;
    logic                   m_sgl;
    logic                   report;
    logic [DATA_W-1:0]      sel_data;
    rpt_class_e             cls_q;
    rpt_class_e             cap_cls_e;
    logic [NUM_BANKS-1:0]   b_vld;
    logic [1:0]             b_ecc  [NUM_BANKS];
    logic [DATA_W-1:0]      b_data [NUM_BANKS];

    // Gather the two banks into indexed form, even bank at index 0.
    always_comb begin
        b_vld     = {od_vld, ev_vld};
        b_ecc[0]  = ev_ecc;
        b_ecc[1]  = od_ecc;
        b_data[0] = ev_data;
        b_data[1] = od_data;
    end

    ecc_sev_merge u_merge (
        .ev_vld   (ev_vld),
        .ev_ecc   (ev_ecc),
        .od_vld   (od_vld),
        .od_ecc   (od_ecc),
        .cls      (m_cls),
        .pick_odd (m_pick_odd),
        .is_mul   (m_mul),
        .is_sgl   (m_sgl)
    );

    ecc_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_rdata)
    );

    // One registered data lane per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
        ecc_lane_mark #(.DATA_W(DATA_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (b_vld[b]),
            .code   (b_ecc[b]),
            .data   (b_data[b]),
            .q_data (rd_data[b*DATA_W +: DATA_W]),
            .q_fix  (rd_fix[b]),
            .q_bad  (rd_bad[b])
        );
    end

    // Decide whether this access's error type is enabled for reporting.
    always_comb begin
        report   = (m_mul && cfg_rdata[CFG_MUL_BIT]) ||
                   (m_sgl && cfg_rdata[CFG_SGL_BIT]);
        sel_data = m_pick_odd ? od_data : ev_data;
    end

    // Register the bus response and the merged class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            cls_q     <= RPT_NONE;
        end else begin
            rsp_valid <= ev_vld || od_vld;
            rsp_err   <= m_mul;
            cls_q     <= m_cls;
        end
    end

    ecc_fault_capture #(
        .ADDR_W (ADDR_W),
        .ATTR_W (ATTR_W),
        .MSTR_W (MSTR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .report    (report),
        .clr       (irq_clr),
        .cls       (m_cls),
        .addr      (acc_addr),
        .attr      (acc_attr),
        .mstr      (acc_mstr),
        .data      (sel_data),
        .irq       (irq),
        .cap_class (cap_cls_e),
        .cap_addr  (cap_addr),
        .cap_attr  (cap_attr),
        .cap_mstr  (cap_mstr),
        .cap_data  (cap_data)
    );

    // Present the enum-typed classes as plain vectors at the ports.
    always_comb begin
        rpt_class = cls_q;
        cap_class = cap_cls_e;
    end

endmodule

// File: rtl/bank_ecc_reporter_chk.sv
// Property checker for bank_ecc_reporter, attached with bind below.
// Observes ports only; every property is disabled during reset.
module bank_ecc_reporter_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int ATTR_W = 4,
    parameter int MSTR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_vld,
    input logic [1:0]        ev_ecc,
    input logic              od_vld,
    input logic [1:0]        od_ecc,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [7:0]        cfg_rdata,
    input logic              irq_clr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [2:0]        rpt_class,
    input logic [1:0]        rd_bad,
    input logic              irq,
    input logic [2:0]        cap_class,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [DATA_W-1:0] cap_data
);

    a_r2_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_vld && !od_vld) |=> (!rsp_valid && !rsp_err && rpt_class == 3'd0));

    a_r5_multi_err: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_vld && ev_ecc[1]) || (od_vld && od_ecc[1])) |=> rsp_err);

    a_r5_single_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ev_vld && ev_ecc[1]) && !(od_vld && od_ecc[1])) |=> !rsp_err);

    a_r4_tie_single_even: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && od_vld && ev_ecc == 2'b01 && od_ecc == 2'b01) |=> rpt_class == 3'd1);

    a_r4_tie_multi_even: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && od_vld && ev_ecc[1] && od_ecc[1]) |=> rpt_class == 3'd2);

    a_r6_even_bad_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vld && ev_ecc[1]) |=> rd_bad[0]);

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:2] == 6'd0);

    a_r8_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[0] && !irq && ev_vld && ev_ecc[1]) |=> (irq && cap_addr == $past(acc_addr)));

    a_r9_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] == 2'b00 && !irq) |=> !irq);

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> (irq && $stable(cap_addr) && $stable(cap_class) && $stable(cap_data)));

    a_r11_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !ev_vld && !od_vld) |=> (!irq && cap_addr == '0));

endmodule

bind bank_ecc_reporter bank_ecc_reporter_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .ATTR_W (ATTR_W),
    .MSTR_W (MSTR_W)
) u_chk (.*);

// File: tb/bank_ecc_reporter_test.sv
module bank_ecc_reporter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_vld = 1'b0, od_vld = 1'b0;
    logic [1:0]  ev_ecc = '0, od_ecc = '0;
    logic [31:0] ev_data = '0, od_data = '0, acc_addr = '0;
    logic [3:0]  acc_attr = '0, acc_mstr = '0;
    logic        cfg_we = 1'b0, irq_clr = 1'b0;
    logic [7:0]  cfg_wdata = '0, cfg_rdata;
    logic        rsp_valid, rsp_err, irq;
    logic [2:0]  rpt_class, cap_class;
    logic [63:0] rd_data;
    logic [1:0]  rd_fix, rd_bad;
    logic [31:0] cap_addr, cap_data;
    logic [3:0]  cap_attr, cap_mstr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bank_ecc_reporter uut (.*);

    // Vector: {ev_vld, ev_ecc, od_vld, od_ecc, class, err}
    localparam logic [9:0] VEC [0:15] = '{
        {1'b0, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0},
        {1'b1, 2'd1, 1'b0, 2'd0, 3'd1, 1'b0},
        {1'b1, 2'd2, 1'b0, 2'd0, 3'd2, 1'b1},
        {1'b0, 2'd0, 1'b1, 2'd1, 3'd3, 1'b0},
        {1'b0, 2'd0, 1'b1, 2'd2, 3'd4, 1'b1},
        {1'b1, 2'd0, 1'b1, 2'd0, 3'd0, 1'b0},
        {1'b1, 2'd1, 1'b1, 2'd0, 3'd1, 1'b0},
        {1'b1, 2'd2, 1'b1, 2'd0, 3'd2, 1'b1},
        {1'b1, 2'd0, 1'b1, 2'd1, 3'd3, 1'b0},
        {1'b1, 2'd1, 1'b1, 2'd1, 3'd1, 1'b0},
        {1'b1, 2'd2, 1'b1, 2'd1, 3'd2, 1'b1},
        {1'b1, 2'd0, 1'b1, 2'd2, 3'd4, 1'b1},
        {1'b1, 2'd1, 1'b1, 2'd2, 3'd4, 1'b1},
        {1'b1, 2'd2, 1'b1, 2'd2, 3'd2, 1'b1},
        {1'b1, 2'd3, 1'b0, 2'd0, 3'd2, 1'b1},
        {1'b1, 2'd0, 1'b0, 2'd2, 3'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one access after a falling edge, then return to idle at the next.
    task automatic access(input logic ev, input logic [1:0] ec, input logic [31:0] ed,
                          input logic od, input logic [1:0] oc, input logic [31:0] odd,
                          input logic [31:0] a, input logic [3:0] at, input logic [3:0] m,
                          input logic clr);
        ev_vld = ev; ev_ecc = ec; ev_data = ed;
        od_vld = od; od_ecc = oc; od_data = odd;
        acc_addr = a; acc_attr = at; acc_mstr = m; irq_clr = clr;
        @(negedge clk);
        ev_vld = 1'b0; ev_ecc = '0; ev_data = '0;
        od_vld = 1'b0; od_ecc = '0; od_data = '0;
        acc_addr = '0; acc_attr = '0; acc_mstr = '0; irq_clr = 1'b0;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the bench finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_err", rsp_err, 0);
        chk("R1 rpt_class", rpt_class, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cap_addr", cap_addr, 0);
        chk("R1 cfg_rdata", cfg_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R12: table of all merge cases, reporting disabled
        for (int i = 0; i < 16; i++) begin
            logic [9:0]  v;
            logic [31:0] ed, odd;
            v   = VEC[i];
            ed  = 32'hE000_0000 | 32'(i);
            odd = 32'h0D00_0000 | 32'(i);
            access(v[9], v[8:7], ed, v[6], v[5:4], odd, 32'h100 + 32'(i), 4'd0, 4'd0, 1'b0);
            chk("R3 R4 rpt_class", rpt_class, v[3:1]);
            chk("R5 rsp_err", rsp_err, v[0]);
            chk("R5 rsp_valid", rsp_valid, v[9] | v[6]);
            chk("R6 rd_data", rd_data, {v[6] ? odd : 32'h0, v[9] ? ed : 32'h0});
            chk("R6 rd_fix", rd_fix, {v[6] && v[5:4] == 2'd1, v[9] && v[8:7] == 2'd1});
            chk("R6 rd_bad", rd_bad, {v[6] && v[5], v[9] && v[8]});
            chk("R9 irq stays low with reporting off", irq, 0);
        end

        // R12: results hold until the next edge, then idle
        @(negedge clk);
        chk("R12 idle after access", rsp_valid, 0);
        chk("R2 idle class", rpt_class, 0);

        // R7: configuration write and readback
        write_cfg(8'hFF);
        chk("R7 cfg readback masks upper bits", cfg_rdata, 8'h03);
        write_cfg(8'h01);
        chk("R7 cfg multi only", cfg_rdata, 8'h01);

        // R9: single error not reported while only multi is enabled
        access(1, 2'd1, 32'h1111_0000, 0, 2'd0, 0, 32'hA0, 4'h1, 4'h2, 0);
        chk("R9 single disabled no irq", irq, 0);
        chk("R9 single disabled no capture", cap_class, 0);

        // R8: multi-bit odd error captured, odd data selected
        access(1, 2'd1, 32'h2222_0000, 1, 2'd2, 32'h3333_0000, 32'hB0, 4'h5, 4'h3, 0);
        chk("R8 irq raised", irq, 1);
        chk("R8 cap_class odd multi", cap_class, 3'd4);
        chk("R8 cap_addr", cap_addr, 32'hB0);
        chk("R8 cap_attr", cap_attr, 4'h5);
        chk("R8 cap_mstr", cap_mstr, 4'h3);
        chk("R8 cap_data odd bank", cap_data, 32'h3333_0000);

        // R10: later error while pending leaves capture alone
        access(1, 2'd2, 32'h4444_0000, 0, 2'd0, 0, 32'hC0, 4'h7, 4'h9, 0);
        chk("R10 irq held", irq, 1);
        chk("R10 cap_addr held", cap_addr, 32'hB0);
        chk("R10 cap_class held", cap_class, 3'd4);
        chk("R10 cap_data held", cap_data, 32'h3333_0000);

        // R11: clear alone zeroes capture
        access(0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 1);
        chk("R11 irq cleared", irq, 0);
        chk("R11 cap_addr cleared", cap_addr, 0);
        chk("R11 cap_mstr cleared", cap_mstr, 0);

        // R7 R8: single enabled, even single captured with even data
        write_cfg(8'h02);
        access(1, 2'd1, 32'h5555_0000, 1, 2'd0, 32'h6666_0000, 32'hD0, 4'h2, 4'h4, 0);
        chk("R8 single reported irq", irq, 1);
        chk("R8 single cap_class", cap_class, 3'd1);
        chk("R8 single cap_data even", cap_data, 32'h5555_0000);
        chk("R5 single stays okay", rsp_err, 0);

        // R11: clear with a coincident reported error keeps the new one
        access(0, 2'd0, 0, 1, 2'd1, 32'h7777_0000, 32'hE0, 4'h3, 4'h6, 1);
        chk("R11 coincident irq", irq, 1);
        chk("R11 coincident cap_addr", cap_addr, 32'hE0);
        chk("R11 coincident cap_class", cap_class, 3'd3);

        // R9: multi not enabled now, after clear nothing is captured
        access(0, 2'd0, 0, 0, 2'd0, 0, 0, 0, 0, 1);
        access(1, 2'd2, 32'h8888_0000, 0, 2'd0, 0, 32'hF0, 0, 0, 0);
        chk("R9 multi disabled no irq", irq, 0);
        chk("R9 response still error", rsp_err, 1);

        // R1: reset mid-run clears configuration and capture
        write_cfg(8'h03);
        access(1, 2'd2, 32'h9999_0000, 0, 2'd0, 0, 32'h44, 0, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears irq", irq, 0);
        chk("R1 reset clears cfg", cfg_rdata, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule